// File: doc/BRIEF.md
# Dual-Clock Conversion Sequencer

This block sequences a four-input analog-to-digital converter. It does not contain the converter's analog part. Software asks for a conversion with a start strobe and picks the input with a two-bit channel code. The block reports progress through a busy flag and a complete flag. When the complete flag rises, the block latches an eight-bit digital stand-in for the converted value into a result register. That value stays readable until the next conversion completes.

The conversion can be timed in two ways, chosen per conversion by a select bit. The first uses machine cycles of the CPU clock, where one machine cycle is six CPU clocks. The second counts edges of a separate, free-running RC oscillator. On the RC path, the request crosses into the RC domain as a toggle through a two-flop synchronizer. The finish returns the same way. The CPU side then aligns the end of the conversion to machine-cycle boundaries.

In the last machine cycle of every conversion, busy and complete are both high. After that, busy drops. A new start is accepted only when the block is not busy and the complete flag is clear. A clear issued in the same cycle as a start counts as applied first.

Top module: `adc_seq_ctrl`

## Requirements
- R1: During and right after reset, busy, done, chan_hold and result are all 0.
- R2: A start seen with busy=0 and done=0 sets busy in the next cycle.
- R3: On the CPU-clock path (select 0 at start), done rises 180 clock edges after the accepting edge, and busy falls 186 edges after it (31 machine cycles of 6 clocks).
- R4: On both paths, done rises while busy is still 1. Busy falls exactly 6 clocks (one machine cycle) later, with done still 1.
- R5: A start while busy=1 is ignored: the channel and the timing of the running conversion are unchanged.
- R6: A start while done=1 is ignored unless clear_done is high in the same cycle. In that case the start is accepted and done goes to 0.
- R7: With busy=0, clear_done drops done in the next cycle and leaves result unchanged. clear_done has no effect while busy=1.
- R8: chan_hold takes chan_sel when a start is accepted (code 0 to 3 selects input 0 to 3) and holds it for the whole conversion.
- R9: result takes the sample_in value present at the edge where done rises and changes at no other time.
- R10: On the RC path (select 1 at start), the busy time T satisfies RC_CYCLES RC periods <= T <= (RC_CYCLES+6) RC periods + 5 machine cycles.
- R11: The select bit is sampled only when a start is accepted. Changing it during a conversion does not change that conversion's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rc_clk | input | 1 | Free-running RC oscillator clock |
| start | input | 1 | Conversion request strobe |
| clear_done | input | 1 | Clears the complete flag |
| rc_sel | input | 1 | 1 selects RC-clock timing, 0 selects CPU machine cycles |
| chan_sel | input | 2 | Input channel code |
| sample_in | input | 8 | Digital stand-in for the conversion value |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Conversion complete |
| chan_hold | output | 2 | Channel routed to the converter input mux |
| result | output | 8 | Last latched conversion value |

## Verification
A wrong machine-cycle count or a wrong prescaler phase shows as done or busy moving on the wrong edge. On the CPU path that error is exact to the clock, and it is visible within one conversion of 186 cycles. A lost toggle in either crossing leaves busy stuck high, which shows as an out-of-range busy time on the next RC conversion. A broken start lockout shows within one cycle of the stray strobe, as a changed chan_hold or a shifted finish. A result register that loads at the wrong moment shows as a mismatch against the sample present when done rose.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic {
        SRC_CPU = 1'b0,
        SRC_RC  = 1'b1
    } tbase_e;

    localparam int DEF_MC_CLKS   = 6;
    localparam int DEF_CPU_MCS   = 31;
    localparam int DEF_RC_CYCLES = 108;
    localparam int DEF_RC_END_MC = 3;
endpackage

// File: rtl/adc_sync2.sv
module adc_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/adc_mc_prescaler.sv
module adc_mc_prescaler #(
    parameter int LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart || cnt_q == LAST) cnt_d = '0;
        else                          cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == LAST) && !restart;

    p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/adc_rc_engine.sv
module adc_rc_engine #(
    parameter int CYCLES = 108
) (
    input  logic rc_clk,
    input  logic rst_n,
    input  logic req_tgl,
    output logic ack_tgl
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    typedef struct packed {
        logic          prev;
        logic          run;
        logic [CW-1:0] cnt;
        logic          ack;
    } rc_st_t;

    logic   req_s;
    rc_st_t st_d, st_q;

    adc_sync2 #(.W(1)) u_req_sync (
        .clk  (rc_clk),
        .rst_n(rst_n),
        .d    (req_tgl),
        .q    (req_s)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = req_s;
        if (req_s != st_q.prev) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.run) begin
            if (st_q.cnt == LAST) begin
                st_d.run = 1'b0;
                st_d.ack = ~st_q.ack;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge rc_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_tgl = st_q.ack;

    p_ack_after_run_r10: assert property (@(posedge rc_clk) disable iff (!rst_n)
        !$stable(st_q.ack) |-> $past(st_q.run));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CH_W      = 2,
    parameter int MC_CLKS   = DEF_MC_CLKS,
    parameter int CPU_MCS   = DEF_CPU_MCS,
    parameter int RC_CYCLES = DEF_RC_CYCLES,
    parameter int RC_END_MC = DEF_RC_END_MC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rc_clk,
    input  logic              start,
    input  logic              clear_done,
    input  logic              rc_sel,
    input  logic [CH_W-1:0]   chan_sel,
    input  logic [DATA_W-1:0] sample_in,
    output logic              busy,
    output logic              done,
    output logic [CH_W-1:0]   chan_hold,
    output logic [DATA_W-1:0] result
);
    localparam int MCNT_W = $clog2(CPU_MCS + 1);
    localparam logic [MCNT_W-1:0] CPU_DONE_AT = MCNT_W'(CPU_MCS - 1);
    localparam logic [MCNT_W-1:0] CPU_END_AT  = MCNT_W'(CPU_MCS);
    localparam logic [MCNT_W-1:0] RC_DONE_AT  = MCNT_W'(RC_END_MC - 1);
    localparam logic [MCNT_W-1:0] RC_END_AT   = MCNT_W'(RC_END_MC);

    typedef struct packed {
        logic              busy;
        logic              done;
        tbase_e            src;
        logic [CH_W-1:0]   chan;
        logic [MCNT_W-1:0] mcnt;
        logic [DATA_W-1:0] res;
        logic              req_tgl;
        logic              ack_prev;
        logic              ack_seen;
    } st_t;

    st_t  st_d, st_q;
    logic accept;
    logic mc_tick;
    logic ack_tgl;
    logic ack_s;

    assign accept = start && !st_q.busy && (!st_q.done || clear_done);

    adc_mc_prescaler #(.LEN(MC_CLKS)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(accept),
        .tick   (mc_tick)
    );

    adc_rc_engine #(.CYCLES(RC_CYCLES)) u_rc (
        .rc_clk (rc_clk),
        .rst_n  (rst_n),
        .req_tgl(st_q.req_tgl),
        .ack_tgl(ack_tgl)
    );

    adc_sync2 #(.W(1)) u_ack_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ack_tgl),
        .q    (ack_s)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ack_prev = ack_s;
        if (clear_done && !st_q.busy) st_d.done = 1'b0;

        if (accept) begin
            st_d.busy     = 1'b1;
            st_d.src      = rc_sel ? SRC_RC : SRC_CPU;
            st_d.chan     = chan_sel;
            st_d.mcnt     = '0;
            st_d.ack_seen = 1'b0;
            if (rc_sel) st_d.req_tgl = ~st_q.req_tgl;
        end else if (st_q.busy) begin
            if (st_q.src == SRC_CPU) begin
                if (mc_tick) begin
                    st_d.mcnt = st_q.mcnt + 1'b1;
                    if (st_d.mcnt == CPU_DONE_AT) begin
                        st_d.done = 1'b1;
                        st_d.res  = sample_in;
                    end
                    if (st_d.mcnt == CPU_END_AT) st_d.busy = 1'b0;
                end
            end else begin
                if (!st_q.ack_seen) begin
                    if (ack_s != st_q.ack_prev) st_d.ack_seen = 1'b1;
                end else if (mc_tick) begin
                    st_d.mcnt = st_q.mcnt + 1'b1;
                    if (st_d.mcnt == RC_DONE_AT) begin
                        st_d.done = 1'b1;
                        st_d.res  = sample_in;
                    end
                    if (st_d.mcnt == RC_END_AT) st_d.busy = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign chan_hold = st_q.chan;
    assign result    = st_q.res;

    p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start) |=> busy);

    p_start_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && done && start && !clear_done) |=> (!busy && done));

    p_chan_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(chan_hold));

    p_result_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done) |-> $stable(result));

    p_done_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> busy);

    p_busy_ends_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_clear_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_done && !busy && !start) |=> !done);
endmodule

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
    localparam int  RC_CYC  = 108;
    localparam real TCPU    = 5.0;
    localparam real TRC     = 7.0;

    logic       clk = 0, rc_clk = 0, rst_n = 0;
    logic       start = 0, clear_done = 0, rc_sel = 0;
    logic [1:0] chan_sel = 0;
    logic [7:0] sample_in = 0;
    logic       busy, done;
    logic [1:0] chan_hold;
    logic [7:0] result;

    int  checks = 0, errors = 0;
    bit  finished = 0;

    always #2.5 clk = ~clk;
    always #3.5 rc_clk = ~rc_clk;

    adc_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rc_clk(rc_clk), .start(start),
        .clear_done(clear_done), .rc_sel(rc_sel), .chan_sel(chan_sel),
        .sample_in(sample_in), .busy(busy), .done(done),
        .chan_hold(chan_hold), .result(result)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic bit rc_in_range(input int nb);
        real t;
        t = nb * TCPU;
        return (t >= RC_CYC * TRC) && (t <= (RC_CYC + 6) * TRC + 5 * 6 * TCPU);
    endfunction

    task automatic run_conv(input bit rc, input int ch, input bit with_clear, input bit noise);
        int  n, nd, nb, exp_res;
        bit  chan_bad;
        logic [7:0] cur;
        start = 1; rc_sel = rc; chan_sel = 2'(ch); clear_done = with_clear;
        step();
        start = 0; clear_done = 0;
        rc_sel = ~rc;                      // R11: must not matter
        chan_sel = 2'($urandom);
        chk(busy === 1'b1, "R2", busy, 1);
        if (with_clear) chk(done === 1'b0, "R6", done, 0);
        chk(chan_hold === 2'(ch), "R8", chan_hold, ch);
        nd = -1; nb = -1; n = 0; chan_bad = 0; exp_res = 0;
        cur = sample_in;
        while (nb < 0 && n < 400) begin
            step();
            n++;
            if (done && nd < 0) begin nd = n; exp_res = cur; end
            if (!busy) nb = n;
            if (busy && chan_hold !== 2'(ch)) chan_bad = 1;
            start = 0;
            if (noise && n == 20) begin start = 1; chan_sel = 2'(ch + 1); end  // R5
            cur = 8'($urandom);
            sample_in = cur;
        end
        start = 0;
        chk(!chan_bad, "R8", chan_bad, 0);
        chk(result === 8'(exp_res), "R9", result, exp_res);
        chk(nb - nd == 6, "R4", nb - nd, 6);
        if (!rc) begin
            chk(nd == 180, "R3", nd, 180);
            chk(nb == 186, noise ? "R5" : "R3", nb, 186);
        end else begin
            chk(rc_in_range(nb), noise ? "R10_R5" : "R10_R11", nb, RC_CYC);
        end
    endtask

    task automatic post_checks(input bit do_clear);
        logic [7:0] keep;
        keep = result;
        start = 1; chan_sel = 2'($urandom);
        step();
        start = 0;
        chk(busy === 1'b0 && done === 1'b1, "R6", {busy, done}, 1);
        sample_in = 8'($urandom);
        step();
        chk(result === keep, "R9", result, keep);
        if (do_clear) begin
            clear_done = 1;
            step();
            clear_done = 0;
            chk(done === 1'b0, "R7", done, 0);
            chk(result === keep, "R7", result, keep);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) step();
        chk(busy === 0 && done === 0, "R1", {busy, done}, 0);
        chk(chan_hold === 0 && result === 0, "R1", {chan_hold, result}, 0);
        rst_n = 1;
        step();
        step();
        chk(busy === 0 && done === 0, "R1", {busy, done}, 0);
        // directed: every channel code on the CPU path, then RC path
        for (int c = 0; c < 4; c++) begin
            run_conv(1'b0, c, c != 0, c == 2);
            post_checks(c == 3);
        end
        run_conv(1'b1, 1, 1'b0, 1'b0);
        post_checks(1'b0);
        run_conv(1'b1, 3, 1'b1, 1'b1);
        post_checks(1'b1);
        // random mix
        for (int i = 0; i < 8; i++) begin
            bit rc;
            bit clr;
            rc  = 1'($urandom);
            clr = 1'($urandom);
            run_conv(rc, int'($urandom % 4), 1'b1, 1'($urandom));
            post_checks(clr);
            repeat (int'($urandom % 5)) step();
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule